// File: doc/BRIEF.md
# Configuration Transaction Bridge

This block sits on a simple 32-bit register bus and lets software run single-word configuration accesses against devices behind a board control bus. Software loads a data word, writes a packed command word with its start bit set, and polls a status word until it reports completion or error. The command word addresses one target by controller index, function code, site, board position and device number, and selects read or write.

A launched command leaves the register front end as a one-cycle request toward a request/response port. A responder model inside the block answers that port. It holds a small array of device words, replies after a fixed, parameterised number of cycles, and flags an error for targets it does not map. A watchdog counter ends a command with an error when no reply arrives. While a command is in flight the start bit reads back as 1, so software can use it as a busy flag.

Top module: `cfgb_bridge`

## Requirements
- R1: After reset the data, control and status registers all read zero.
- R2: The data register is at byte offset 0xA0, control at 0xA4 and status at 0xA8. A read of any other offset returns zero.
- R3: Control bit 31 is start and bit 30 selects write (1) or read (0). Bits 29:26 are the controller index, 25:20 the function code, 17:16 the site, 15:12 the position and 11:0 the device number. A control write with bit 31 clear, made while idle, is stored and read back unchanged and starts no transaction, so status stays zero.
- R4: While a command is in flight, control reads back the launched word with bit 31 set. Bit 31 clears on the same clock edge that sets status.
- R5: Status stays zero through the LATENCY edges that follow the launching write. It becomes nonzero at edge LATENCY+1.
- R6: A write command whose function code equals MAP_FUNC (default 1) and whose device number is below NUM_DEV stores the data register into that device word. Status then reads 1 (bit 0 = complete).
- R7: A read command to a mapped target loads the device word into the data register, and status reads 1.
- R8: A command to any other function code (except the silent one) or to a device number of NUM_DEV or more ends with status 2 (bit 1 = error, bit 0 clear). It leaves the data register and all device words unchanged.
- R9: A command with function code SILENT_FUNC (default 0x3F) gets no reply. Start stays set through TIMEOUT-1 edges after launch, and at edge TIMEOUT status becomes 2 and start clears.
- R10: While start reads 1, writes to the control and data registers are ignored. The command in flight and its data are unaffected.
- R11: Any write to the status register clears it to zero, whatever the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |

## Verification
A stuck or early-clearing busy state shows at the ports as a status word that changes one or more edges away from LATENCY+1. The bench checks that edge exactly for every command. A busy flag that does not block writes shows as a control readback that no longer matches the launched word, or as a device word that holds the wrong value when it is read back in the next command. A wrong error path shows as a data register that was overwritten, or as status 3. The timeout is checked on both sides of edge TIMEOUT.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   localparam int WORD_W = 32;

   localparam logic [7:0] OFS_DATA = 8'hA0;
   localparam logic [7:0] OFS_CTRL = 8'hA4;
   localparam logic [7:0] OFS_STAT = 8'hA8;

   localparam logic [1:0] STAT_DONE = 2'b01;
   localparam logic [1:0] STAT_ERR  = 2'b10;

   typedef struct packed {
      logic        start;
      logic        wr;
      logic [3:0]  ctl_idx;
      logic [5:0]  func;
      logic [1:0]  spare;
      logic [1:0]  site;
      logic [3:0]  pos;
      logic [11:0] dev;
   } cmd_t;
endpackage

// File: rtl/cfgb_engine.sv
module cfgb_engine
   import cfgb_pkg::*;
#(
   parameter int TIMEOUT = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data_en,
   input  logic              wr_ctrl_en,
   input  logic              wr_stat_en,
   input  logic [WORD_W-1:0] wdata,
   output cmd_t              ctrl_q,
   output logic [WORD_W-1:0] data_q,
   output logic [1:0]        stat_q,
   output logic              req_valid,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   input  logic [WORD_W-1:0] rsp_rdata
);
   localparam int TW = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("cfgb_engine: TIMEOUT must be at least 2");
   end

   logic          busy;
   logic          launch;
   logic [TW-1:0] tcnt;
   logic          expired;

   assign busy    = ctrl_q.start;
   assign launch  = wr_ctrl_en && !busy && wdata[WORD_W-1];
   assign expired = busy && (tcnt == TW'(TIMEOUT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         data_q    <= '0;
         stat_q    <= '0;
         req_valid <= 1'b0;
         tcnt      <= '0;
      end else begin
         req_valid <= launch;
         if (wr_ctrl_en && !busy) ctrl_q <= cmd_t'(wdata);
         if (wr_data_en && !busy) data_q <= wdata;
         if (wr_stat_en)          stat_q <= '0;
         if (launch)    tcnt <= '0;
         else if (busy) tcnt <= tcnt + 1'b1;
         if (busy && rsp_valid) begin
            ctrl_q.start <= 1'b0;
            stat_q       <= rsp_err ? STAT_ERR : STAT_DONE;
            if (!ctrl_q.wr && !rsp_err) data_q <= rsp_rdata;
         end else if (expired) begin
            ctrl_q.start <= 1'b0;
            stat_q       <= STAT_ERR;
         end
      end
   end

   AST_START_FALL_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q.start) |-> (stat_q != 2'b00)); // R4
   AST_BUSY_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.start && $past(ctrl_q.start)) |-> $stable(ctrl_q)); // R10
   AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stat_q) <= 1); // R8
   AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.start && rsp_valid && rsp_err) |=> $stable(data_q)); // R8
   AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.start |-> (tcnt < TW'(TIMEOUT))); // R9
endmodule

// File: rtl/cfgb_responder.sv
module cfgb_responder
   import cfgb_pkg::*;
#(
   parameter int          NUM_DEV     = 8,
   parameter int          LATENCY     = 4,
   parameter logic [5:0]  MAP_FUNC    = 6'h01,
   parameter logic [5:0]  SILENT_FUNC = 6'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [5:0]        req_func,
   input  logic [11:0]       req_dev,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [WORD_W-1:0] rsp_rdata
);
   localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

   if (LATENCY < 1 || LATENCY > 255) begin : g_bad_latency
      $error("cfgb_responder: LATENCY must lie in 1..255");
   end
   if (NUM_DEV < 1 || NUM_DEV > 4096) begin : g_bad_ndev
      $error("cfgb_responder: NUM_DEV must lie in 1..4096");
   end

   logic [WORD_W-1:0] mem [NUM_DEV];
   logic              pend;
   logic              hit_q;
   logic              wr_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] wd_q;
   logic              hit;
   logic              accept;

   assign hit    = (req_func == MAP_FUNC) && (req_dev < 12'(NUM_DEV));
   assign accept = req_valid && (req_func != SILENT_FUNC);

   if (LATENCY == 1) begin : g_lat_one
      assign rsp_valid = pend;
   end else begin : g_lat_cnt
      logic [7:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)      cnt <= '0;
         else if (accept) cnt <= 8'(LATENCY);
         else if (pend)   cnt <= cnt - 8'd1;
      end
      assign rsp_valid = pend && (cnt == 8'd1);
   end

   assign rsp_err   = !hit_q;
   assign rsp_rdata = hit_q ? mem[idx_q] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend  <= 1'b0;
         hit_q <= 1'b0;
         wr_q  <= 1'b0;
         idx_q <= '0;
         wd_q  <= '0;
         for (int i = 0; i < NUM_DEV; i++) mem[i] <= '0;
      end else begin
         if (accept) begin
            pend  <= 1'b1;
            hit_q <= hit;
            wr_q  <= req_write;
            idx_q <= req_dev[IDX_W-1:0];
            wd_q  <= req_wdata;
         end else if (rsp_valid) begin
            pend <= 1'b0;
         end
         if (rsp_valid && hit_q && wr_q) mem[idx_q] <= wd_q;
      end
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !pend); // R5
   AST_SILENT_NO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_func == SILENT_FUNC) |=> !pend); // R9
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
   import cfgb_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         NUM_DEV     = 8,
   parameter int         LATENCY     = 4,
   parameter int         TIMEOUT     = 1024,
   parameter logic [5:0] MAP_FUNC    = 6'h01,
   parameter logic [5:0] SILENT_FUNC = 6'h3F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("cfgb_bridge: ADDR_W must be at least 8");
   end
   if (LATENCY >= TIMEOUT) begin : g_bad_window
      $error("cfgb_bridge: LATENCY must be below TIMEOUT");
   end

   logic              hit_data, hit_ctrl, hit_stat;
   cmd_t              ctrl_q;
   logic [WORD_W-1:0] data_q;
   logic [1:0]        stat_q;
   logic              req_valid, rsp_valid, rsp_err;
   logic [WORD_W-1:0] rsp_rdata;

   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));

   cfgb_engine #(.TIMEOUT(TIMEOUT)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data_en (bus_sel && bus_wr && hit_data),
      .wr_ctrl_en (bus_sel && bus_wr && hit_ctrl),
      .wr_stat_en (bus_sel && bus_wr && hit_stat),
      .wdata      (bus_wdata),
      .ctrl_q     (ctrl_q),
      .data_q     (data_q),
      .stat_q     (stat_q),
      .req_valid  (req_valid),
      .rsp_valid  (rsp_valid),
      .rsp_err    (rsp_err),
      .rsp_rdata  (rsp_rdata)
   );

   cfgb_responder #(
      .NUM_DEV     (NUM_DEV),
      .LATENCY     (LATENCY),
      .MAP_FUNC    (MAP_FUNC),
      .SILENT_FUNC (SILENT_FUNC)
   ) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (ctrl_q.wr),
      .req_func  (ctrl_q.func),
      .req_dev   (ctrl_q.dev),
      .req_wdata (data_q),
      .rsp_valid (rsp_valid),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (hit_data)      bus_rdata = data_q;
         else if (hit_ctrl) bus_rdata = ctrl_q;
         else if (hit_stat) bus_rdata = {30'd0, stat_q};
      end
   end
endmodule

// File: tb/cfgb_bridge_test.sv
module cfgb_bridge_test;
   localparam int LAT  = 4;
   localparam int TMO  = 1024;
   localparam int NDEV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cfgb_bridge #(.ADDR_W(8), .NUM_DEV(NDEV), .LATENCY(LAT), .TIMEOUT(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [31:0] cmd(bit st, bit w, logic [5:0] f, logic [11:0] dev, int k);
      return {st, w, 4'(k), f, 2'b00, 2'(k), 4'(k + 3), dev};
   endfunction

   function automatic logic [31:0] pat(int d);
      return 32'hA500_0000 ^ (32'(d) * 32'h0102_0304);
   endfunction

   // Launch c, check that it is pending just before the expected edge and finished right after it.
   task automatic run(string req, logic [31:0] c, int win, logic [1:0] exp_st);
      logic [31:0] v;
      wr(8'hA8, 32'h0);
      wr(8'hA4, c);
      rd(8'hA4, v); chk("R4 busy readback", v, c);
      repeat (win) @(negedge clk);
      rd(8'hA8, v); chk({req, " pending"}, v, 32'h0);
      rd(8'hA4, v); chk("R4 start held", 32'(v[31]), 32'd1);
      @(negedge clk);
      rd(8'hA8, v); chk({req, " status"}, v, 32'(exp_st));
      rd(8'hA4, v); chk("R4 start cleared with status", v, {1'b0, c[30:0]});
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(8'hA0, v); chk("R1 data", v, 0);
      rd(8'hA4, v); chk("R1 ctrl", v, 0);
      rd(8'hA8, v); chk("R1 stat", v, 0);

      wr(8'hA0, 32'h1234_5678);
      rd(8'hA0, v); chk("R2 data offset", v, 32'h1234_5678);
      rd(8'hAC, v); chk("R2 unmapped offset", v, 0);
      rd(8'h20, v); chk("R2 unmapped offset low", v, 0);

      wr(8'hA4, 32'h7ABC_D123);
      rd(8'hA4, v); chk("R3 idle ctrl store", v, 32'h7ABC_D123);
      repeat (LAT + 3) @(negedge clk);
      rd(8'hA8, v); chk("R3 no launch", v, 0);

      for (int d = 0; d < NDEV; d++) begin
         wr(8'hA0, pat(d));
         run("R5 R6 write", cmd(1, 1, 6'h01, 12'(d), d), LAT, 2'b01);
      end
      for (int d = 0; d < NDEV; d++) begin
         wr(8'hA0, 32'hDEAD_BEEF);
         run("R5 R7 read", cmd(1, 0, 6'h01, 12'(d), d + 1), LAT, 2'b01);
         rd(8'hA0, v); chk("R7 read data", v, pat(d));
      end

      wr(8'hA0, 32'hDEAD_BEEF);
      run("R8 bad func read", cmd(1, 0, 6'h02, 12'd0, 2), LAT, 2'b10);
      rd(8'hA0, v); chk("R8 data kept", v, 32'hDEAD_BEEF);
      wr(8'hA0, 32'h0BAD_0BAD);
      run("R8 bad device write", cmd(1, 1, 6'h01, 12'(NDEV), 0), LAT, 2'b10);
      run("R8 bad func write", cmd(1, 1, 6'h05, 12'd1, 1), LAT, 2'b10);
      run("R8 readback dev0", cmd(1, 0, 6'h01, 12'd0, 0), LAT, 2'b01);
      rd(8'hA0, v); chk("R8 dev0 untouched", v, pat(0));
      run("R8 readback dev1", cmd(1, 0, 6'h01, 12'd1, 0), LAT, 2'b01);
      rd(8'hA0, v); chk("R8 dev1 untouched", v, pat(1));

      // R10: writes during flight are ignored
      wr(8'hA8, 32'h0);
      wr(8'hA0, 32'h5555_AAAA);
      wr(8'hA4, cmd(1, 1, 6'h01, 12'd2, 0));
      wr(8'hA4, cmd(1, 1, 6'h01, 12'd5, 0));
      wr(8'hA0, 32'h0000_0000);
      rd(8'hA4, v); chk("R10 ctrl kept", v, cmd(1, 1, 6'h01, 12'd2, 0));
      rd(8'hA0, v); chk("R10 data kept", v, 32'h5555_AAAA);
      repeat (LAT + 2) @(negedge clk);
      run("R10 read dev2", cmd(1, 0, 6'h01, 12'd2, 0), LAT, 2'b01);
      rd(8'hA0, v); chk("R10 dev2 value", v, 32'h5555_AAAA);
      run("R10 read dev5", cmd(1, 0, 6'h01, 12'd5, 0), LAT, 2'b01);
      rd(8'hA0, v); chk("R10 dev5 untouched", v, pat(5));

      run("R9 timeout", cmd(1, 0, 6'h3F, 12'd0, 0), TMO - 1, 2'b10);
      rd(8'hA0, v); chk("R9 data kept", v, pat(5));

      wr(8'hA8, 32'hFFFF_FFFF);
      rd(8'hA8, v); chk("R11 status clear", v, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule